// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block sends one card command through a register-mapped SD host controller. The command is given on a parallel interface: an 8-bit index, a 5-bit response descriptor, a 32-bit argument and a flag that marks a data transfer. After a start strobe, the engine acts as a bus master and makes a fixed series of register writes. It first clears pending interrupt status, then masks the interrupt signal, then loads the argument and the transfer mode. Last, it writes the command word, whose flag byte the engine derives from the response descriptor.

Once the command word is written, the engine reads the interrupt status register over and over. A set error bit ends the command with an error pulse. A DMA boundary event is serviced as it occurs: the engine clears the status bits it saw, then reads the system DMA address and writes the same address back, which restarts the transfer. The command ends when the completion bit for this kind of command appears. That bit is data-end for busy or data commands and command-response for all others. The number of boundary events serviced stays on an output until the next command starts.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, bus_req, done and error are low and dma_events is zero.
- R2: A start strobe accepted in idle leads to three full-word writes (bus_be 4'hF), in this order: 32'hFFFFFFFF to address 8'h30, zero to address 8'h38, and the argument to address 8'h08.
- R3: The next access writes the transfer mode to address 8'h0C with bus_be 4'b0011. Its low half is 16'h0037 when the data flag is set and 16'h0000 otherwise. Bits 31:16 are zero.
- R4: The length code in flag bits 1:0 follows a fixed priority. A clear descriptor bit 0 gives 0. Otherwise descriptor bit 1 (long response) gives 1. Otherwise descriptor bit 3 (busy) gives 3. Any other case gives 2.
- R5: Flag bit 3 is descriptor bit 2 (CRC check). Flag bit 4 is descriptor bit 4 (index echoed). Flag bit 5 is the data flag. Flag bits 7:6 and bit 2 are zero.
- R6: The command word is written to address 8'h0C with bus_be 4'b1100. The index goes in bits 31:24, the flags in bits 23:16, and bits 15:0 are zero.
- R7: After the command word, the engine keeps reading address 8'h30 (bus_be 4'hF) until the completion bit is seen. That bit is status bit 1 when descriptor bit 3 or the data flag is set, and status bit 0 otherwise.
- R8: A status read with bit 15 set ends the command with an error pulse and no further access. This check comes before DMA servicing and before completion.
- R9: A status read with bit 3 set, and bit 15 clear, is followed by three accesses: a write of that status value to 8'h30, a read of 8'h00, and a write of the value just read back to 8'h00. dma_events then rises by one, saturating at its maximum. The completion bit is checked in the same status value only after this sequence.
- R10: An access holds bus_req, bus_wr, bus_addr, bus_be and bus_wdata steady until a clock edge with bus_ready high. That edge completes the access, and no two accesses share an edge.
- R11: done or error is high for exactly one cycle, the cycle after the final access completes. The two are never high together, and bus_req is low in that cycle.
- R12: A start strobe that arrives while a command is in progress has no effect on the accesses, the result or dma_events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, taken only when idle |
| cmd_idx | input | 8 | Command index |
| resp_type | input | 5 | Response descriptor |
| cmd_arg | input | 32 | Command argument |
| cmd_data | input | 1 | Command carries a multi-block DMA read |
| bus_req | output | 1 | Access request |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Word-aligned byte address |
| bus_be | output | 4 | Byte enables |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ready on reads |
| bus_ready | input | 1 | Access completes on this edge |
| done | output | 1 | Completion pulse |
| error | output | 1 | Error pulse |
| dma_events | output | CNT_W | DMA boundary events serviced in the last command |

## Verification
The hardest situations to reach are status words that carry several meaningful bits together. One case has a DMA boundary event in the same word as the completion bit, which must be serviced before the engine finishes. Another has the error bit together with both of those bits. The bench scripts the sequence of status values its bus model returns, so it can place these combined words anywhere in a poll. It also varies bus_ready from cycle to cycle, so every access sees stalls of different lengths. A second start strobe is sent partway through a data command to show that it is ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR_ALL,
        S_SIGEN,
        S_ARG,
        S_MODE,
        S_CMD,
        S_POLL,
        S_ACK,
        S_DMA_RD,
        S_DMA_WR
    } eng_state_e;

    // response descriptor bit positions
    localparam int DSC_PRESENT = 0;
    localparam int DSC_LONG    = 1;
    localparam int DSC_CRC     = 2;
    localparam int DSC_BUSY    = 3;
    localparam int DSC_OPCODE  = 4;

    // status bit positions
    localparam int ST_RESP  = 0;
    localparam int ST_XEND  = 1;
    localparam int ST_DMA   = 3;
    localparam int ST_FAULT = 15;

endpackage

// File: rtl/sdcmd_flag_decode.sv
module sdcmd_flag_decode
    import sdcmd_pkg::*;
(
    input  logic [4:0]  dsc,
    input  logic        has_data,
    output logic [7:0]  flags,
    output logic [15:0] mode,
    output logic        end_on_xfer
);
    logic [1:0] len_code;

    always_comb begin
        if (!dsc[DSC_PRESENT])   len_code = 2'd0;
        else if (dsc[DSC_LONG])  len_code = 2'd1;
        else if (dsc[DSC_BUSY])  len_code = 2'd3;
        else                     len_code = 2'd2;
        flags       = {2'b00, has_data, dsc[DSC_OPCODE], dsc[DSC_CRC], 1'b0, len_code};
        mode        = has_data ? 16'h0037 : 16'h0000;
        end_on_xfer = dsc[DSC_BUSY] | has_data;
    end
endmodule

// File: rtl/sdcmd_evt_counter.sv
module sdcmd_evt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                        cnt_d = '0;
        else if (inc && cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !clr) |=> cnt_q == '1); // R9
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        cmd_idx,
    input  logic [4:0]        resp_type,
    input  logic [31:0]       cmd_arg,
    input  logic              cmd_data,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [3:0]        bus_be,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ready,
    output logic              done,
    output logic              error,
    output logic [CNT_W-1:0]  dma_events
);
    localparam logic [ADDR_W-1:0] A_DMA   = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_ARG   = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_SIGEN = ADDR_W'(8'h38);

    typedef struct packed {
        eng_state_e  st;
        logic [7:0]  idx;
        logic [4:0]  dsc;
        logic [31:0] arg;
        logic        dat;
        logic [31:0] stat;
        logic [31:0] dma;
        logic        done;
        logic        err;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic [7:0]  cmd_flags;
    logic [15:0] xfer_mode;
    logic        end_on_xfer;
    logic        hs;
    logic        cnt_clr, cnt_inc;

    sdcmd_flag_decode u_decode (
        .dsc         (r_q.dsc),
        .has_data    (r_q.dat),
        .flags       (cmd_flags),
        .mode        (xfer_mode),
        .end_on_xfer (end_on_xfer)
    );

    sdcmd_evt_counter #(.W(CNT_W)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (dma_events)
    );

    function automatic logic is_end(input logic [31:0] s, input logic on_xfer);
        return on_xfer ? s[ST_XEND] : s[ST_RESP];
    endfunction

    assign hs = bus_ready && (r_q.st != S_IDLE);

    // next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.idx = cmd_idx;
                    r_d.dsc = resp_type;
                    r_d.arg = cmd_arg;
                    r_d.dat = cmd_data;
                    r_d.st  = S_CLR_ALL;
                    cnt_clr = 1'b1;
                end
            end
            S_CLR_ALL: if (hs) r_d.st = S_SIGEN;
            S_SIGEN:   if (hs) r_d.st = S_ARG;
            S_ARG:     if (hs) r_d.st = S_MODE;
            S_MODE:    if (hs) r_d.st = S_CMD;
            S_CMD:     if (hs) r_d.st = S_POLL;
            S_POLL: begin
                if (hs) begin
                    r_d.stat = bus_rdata;
                    if (bus_rdata[ST_FAULT]) begin
                        r_d.err = 1'b1;
                        r_d.st  = S_IDLE;
                    end else if (bus_rdata[ST_DMA]) begin
                        r_d.st = S_ACK;
                    end else if (is_end(bus_rdata, end_on_xfer)) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end
                end
            end
            S_ACK:    if (hs) r_d.st = S_DMA_RD;
            S_DMA_RD: begin
                if (hs) begin
                    r_d.dma = bus_rdata;
                    r_d.st  = S_DMA_WR;
                end
            end
            S_DMA_WR: begin
                if (hs) begin
                    cnt_inc = 1'b1;
                    if (is_end(r_q.stat, end_on_xfer)) begin
                        r_d.done = 1'b1;
                        r_d.st   = S_IDLE;
                    end else begin
                        r_d.st = S_POLL;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // bus drive, decoded from the registered state only
    always_comb begin
        bus_req   = (r_q.st != S_IDLE);
        bus_wr    = 1'b1;
        bus_addr  = A_STAT;
        bus_be    = 4'hF;
        bus_wdata = 32'h0;
        case (r_q.st)
            S_CLR_ALL: bus_wdata = 32'hFFFF_FFFF;
            S_SIGEN:   bus_addr  = A_SIGEN;
            S_ARG: begin
                bus_addr  = A_ARG;
                bus_wdata = r_q.arg;
            end
            S_MODE: begin
                bus_addr  = A_XFER;
                bus_be    = 4'b0011;
                bus_wdata = {16'h0, xfer_mode};
            end
            S_CMD: begin
                bus_addr  = A_XFER;
                bus_be    = 4'b1100;
                bus_wdata = {r_q.idx, cmd_flags, 16'h0};
            end
            S_POLL:   bus_wr = 1'b0;
            S_ACK:    bus_wdata = r_q.stat;
            S_DMA_RD: begin
                bus_wr   = 1'b0;
                bus_addr = A_DMA;
            end
            S_DMA_WR: begin
                bus_addr  = A_DMA;
                bus_wdata = r_q.dma;
            end
            default: bus_wr = 1'b0;
        endcase
    end

    assign done  = r_q.done;
    assign error = r_q.err;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_wr)
                                     && $stable(bus_be) && $stable(bus_wdata))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R11
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!bus_req && !(done && error))); // R11
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> (dma_events == $past(dma_events)
                     || dma_events == $past(dma_events) + CNT_W'(1))); // R9
    AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(bus_req && !bus_wr && bus_ready && bus_rdata[ST_FAULT])); // R8
endmodule

// File: tb/sd_cmd_engine_test.sv
module sd_cmd_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cmd_idx = '0;
    logic [4:0]  resp_type = '0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_data = 1'b0;
    logic        bus_req, bus_wr;
    logic [7:0]  bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic        done, error;
    logic [7:0]  dma_events;

    always #5 clk = ~clk;

    sd_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .resp_type(resp_type), .cmd_arg(cmd_arg), .cmd_data(cmd_data),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .done(done), .error(error), .dma_events(dma_events)
    );

    int vectors = 0;
    int miscompares = 0;

    // expected access list
    logic        q_wr[$];
    logic [7:0]  q_addr[$];
    logic [3:0]  q_be[$];
    logic [31:0] q_data[$];
    int          q_end[$];   // 0 more follows, 1 done, 2 error
    string       q_tag[$];
    logic [31:0] script[$];  // status values the bus model returns
    int          pend = 0;   // result expected at the next sample
    int          exp_cnt = 0;

    task automatic fail(input string tag, input string what, input longint act, input longint exp);
        miscompares++;
        $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic expect_acc(input logic wr, input logic [7:0] a, input logic [3:0] be,
                              input logic [31:0] d, input string tag);
        q_wr.push_back(wr); q_addr.push_back(a); q_be.push_back(be);
        q_data.push_back(d); q_end.push_back(0); q_tag.push_back(tag);
    endtask

    // bus model and per-clock comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 1'b0;
        end else begin
            vectors++;
            if (done !== (pend == 1)) fail("R11", "done", done, pend == 1);
            if (error !== (pend == 2)) fail("R8", "error", error, pend == 2);
            if (pend == 1 && dma_events !== exp_cnt[7:0]) fail("R9", "dma_events", dma_events, exp_cnt);
            pend = 0;
            bus_ready = 1'b0;
            if (bus_req) begin
                if (q_wr.size() == 0) begin
                    fail("R12", "unexpected access at", bus_addr, 0);
                    bus_ready = 1'b1;
                end else if ($urandom_range(0, 2) != 0) begin
                    bus_ready = 1'b1;
                    if (!q_wr[0]) bus_rdata = q_data[0];
                    if (bus_wr !== q_wr[0]) fail(q_tag[0], "direction", bus_wr, q_wr[0]);
                    if (bus_addr !== q_addr[0]) fail(q_tag[0], "address", bus_addr, q_addr[0]);
                    if (bus_be !== q_be[0]) fail(q_tag[0], "byte enables", bus_be, q_be[0]);
                    if (q_wr[0] && bus_wdata !== q_data[0]) fail(q_tag[0], "write data", bus_wdata, q_data[0]);
                    pend = q_end[0];
                    void'(q_wr.pop_front()); void'(q_addr.pop_front()); void'(q_be.pop_front());
                    void'(q_data.pop_front()); void'(q_end.pop_front()); void'(q_tag.pop_front());
                end
            end
        end
    end

    function automatic logic [7:0] ref_flags(input logic [4:0] d, input logic dat);
        logic [7:0] f = 8'h00;
        if (d[0] == 1'b0)      f = 8'h00;
        else if (d[1] == 1'b1) f = 8'h01;
        else if (d[3] == 1'b1) f = 8'h03;
        else                   f = 8'h02;
        if (d[2]) f = f + 8'h08;
        if (d[4]) f = f + 8'h10;
        if (dat)  f = f + 8'h20;
        return f;
    endfunction

    task automatic issue(input logic [7:0] idx, input logic [4:0] d, input logic [31:0] arg,
                         input logic dat, input bit intrude);
        logic [31:0] endmask = (d[3] || dat) ? 32'h2 : 32'h1;
        logic [31:0] dval = 32'h8000_1000;
        exp_cnt = 0;
        expect_acc(1, 8'h30, 4'hF, 32'hFFFF_FFFF, "R2");
        expect_acc(1, 8'h38, 4'hF, 32'h0, "R2");
        expect_acc(1, 8'h08, 4'hF, arg, "R2");
        expect_acc(1, 8'h0C, 4'b0011, dat ? 32'h37 : 32'h0, "R3");
        expect_acc(1, 8'h0C, 4'b1100, {idx, ref_flags(d, dat), 16'h0}, "R4 R5 R6");
        foreach (script[i]) begin
            expect_acc(0, 8'h30, 4'hF, script[i], "R7");
            if (script[i][15]) begin
                q_end[q_end.size()-1] = 2;
                q_tag[q_tag.size()-1] = "R8";
                break;
            end
            if (script[i][3]) begin
                expect_acc(1, 8'h30, 4'hF, script[i], "R9");
                expect_acc(0, 8'h00, 4'hF, dval, "R9");
                expect_acc(1, 8'h00, 4'hF, dval, "R9");
                exp_cnt++;
                dval = dval + 32'h1000;
            end
            if ((script[i] & endmask) != 0) begin
                q_end[q_end.size()-1] = 1;
                break;
            end
        end
        script.delete();
        @(negedge clk);
        cmd_idx = idx; resp_type = d; cmd_arg = arg; cmd_data = dat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            repeat (3) @(negedge clk);
            // R12: second strobe while busy, different command
            cmd_idx = 8'h3F; resp_type = 5'h00; cmd_arg = 32'hDEAD_BEEF; cmd_data = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (q_wr.size() != 0 || pend != 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail("R10", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        vectors++;
        if (bus_req !== 1'b0 || done !== 1'b0 || error !== 1'b0 || dma_events !== 8'h0)
            fail("R1", "reset outputs", {bus_req, done, error, dma_events}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;
        if (bus_req !== 1'b0) fail("R1", "bus_req after reset", bus_req, 0);

        // short response with CRC and index echo, completes on response bit
        script = '{32'h0, 32'h0, 32'h1};
        issue(8'd7, 5'h15, 32'h1000_0000, 1'b0, 1'b0);
        // busy response: response bit alone must not finish (R7)
        script = '{32'h1, 32'h0, 32'h2};
        issue(8'd6, 5'h1D, 32'h03B3_0100, 1'b0, 1'b0);
        // long response
        script = '{32'h1};
        issue(8'd9, 5'h07, 32'h1000_0000, 1'b0, 1'b0);
        // data read with two boundary events, the last one together with data-end, plus a stray strobe
        script = '{32'h8, 32'h0, 32'h1, 32'hA};
        issue(8'd18, 5'h15, 32'h0000_0200, 1'b1, 1'b1);
        // no response expected
        script = '{32'h1};
        issue(8'd0, 5'h00, 32'h0, 1'b0, 1'b0);
        // error takes priority over boundary and completion in the same word
        script = '{32'h0, 32'h8009};
        issue(8'd1, 5'h01, 32'h00FF_8000, 1'b0, 1'b0);
        // long takes priority over busy in the length code; completion on data-end
        script = '{32'h1, 32'h2};
        issue(8'd5, 5'h0B, 32'h1234_5678, 1'b0, 1'b0);
        // data with error right after one boundary event
        script = '{32'h8, 32'h8000};
        issue(8'd18, 5'h15, 32'h0000_0400, 1'b1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule